// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter with Target Busy Tracking

This block picks one winner per cycle among eight initiators that share a pipelined bus. Each initiator holds a distinct 3-bit priority. The eligible requester with the highest priority wins. After a win, the winner falls to priority zero. Every initiator that sat below the winner's old priority moves up one step, whether or not it was requesting. Initiators above the winner keep their priority. Under full load this gives a round-robin order without a rotating pointer, and an initiator that stays idle climbs toward the top, so no initiator can be starved.

The block also tracks when each target is busy, so that only cycles a target can accept are granted. A target is addressed by a 4-bit slot and a 3-bit subnode, which gives 128 targets. The bus reports each operation start in the cycle it begins: a read keeps its target closed for eight cycles, and a write keeps it closed for nine. A request aimed at a closed target is not eligible. The grant is combinational in the arbitration cycle. The winner drives its request cycle on the following cycle.

Top module: `bus_prio_arbiter`

## Requirements
- R1: After reset, initiator i holds priority i, every target is open, and `may_arb_o` is all ones.
- R2: In a cycle with at least one eligible request, `grant_o` is one-hot on the eligible requester with the highest current priority. `winner_o` gives its index and `grant_valid_o` is 1.
- R3: At the clock edge that ends a granting cycle, the winner's priority becomes 0.
- R4: At that same edge, every initiator whose priority was below the winner's old priority increments its priority, requesting or not. Initiators above the winner keep their priority.
- R5: In a cycle with no eligible request, `grant_o` is 0, `grant_valid_o` is 0 and no priority changes.
- R6: When all eight initiators request on every cycle from reset, the winners are 7, 6, 5, 4, 3, 2, 1, 0, and this order then repeats.
- R7: A read start on target T in cycle t closes T for cycles t+1 to t+8; T is open again from cycle t+9. The target number is slot*8 + subnode.
- R8: A write start (`op_write_i`=1) on target T in cycle t closes T for cycles t+1 to t+9; T is open again from cycle t+10.
- R9: `may_arb_o[i]` shows whether the target selected by `tgt_i[7*i +: 7]` is open. A request from an initiator whose target is closed is ignored, and an eligible lower-priority requester wins instead.
- R10: The eight priorities always form a permutation of 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Per-initiator request |
| tgt_i | input | 56 | Per-initiator target, 7 bits each {slot[3:0], subnode[2:0]} |
| op_start_i | input | 1 | An operation starts on the bus this cycle |
| op_write_i | input | 1 | 1 = the starting operation is a write, 0 = read |
| op_tgt_i | input | 7 | Target of the starting operation |
| grant_o | output | 8 | One-hot grant |
| grant_valid_o | output | 1 | A grant is issued this cycle |
| winner_o | output | 3 | Index of the granted initiator |
| may_arb_o | output | 8 | Per-initiator: its target is open |

## Verification
The hardest states to reach are the scrambled priority orders that follow mixed request patterns. In those states the climb of idle initiators decides the next winner. The stimulus table therefore walks a hand-computed chain of sparse, dense and empty request patterns, and each step's expected winner depends on every update before it. Closure windows are counted cycle by cycle around a read and a write on a target with nonzero slot and subnode bits. A blocked high-priority request is placed inside the window, so a lower-priority requester has to win.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned ARB_INITS   = 8;
  localparam int unsigned ARB_SLOT_W  = 4;
  localparam int unsigned ARB_SUB_W   = 3;
  localparam int unsigned ARB_RD_GAP  = 9;
  localparam int unsigned ARB_WR_GAP  = 10;

  typedef enum logic {
    OPK_READ  = 1'b0,
    OPK_WRITE = 1'b1
  } op_kind_e;
endpackage

// File: rtl/arb_target_timer.sv
module arb_target_timer
  import arb_pkg::*;
#(
  parameter int unsigned N_TGT  = 128,
  parameter int unsigned TGT_W  = 7,
  parameter int unsigned RD_GAP = 9,
  parameter int unsigned WR_GAP = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [TGT_W-1:0] tgt_i,
  output logic [N_TGT-1:0] free_o
);
  localparam int unsigned CNT_W = $clog2(WR_GAP + 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_GAP - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_GAP - 1);

  op_kind_e kind;
  assign kind = op_kind_e'(write_i);

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_en;

    always_comb begin
      cnt_en = 1'b0;
      cnt_d  = cnt_q;
      if (start_i && (tgt_i == TGT_W'(t))) begin
        cnt_en = 1'b1;
        cnt_d  = (kind == OPK_WRITE) ? WR_LOAD : RD_LOAD;
      end else if (cnt_q != '0) begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign free_o[t] = (cnt_q == '0);
  end
endmodule

// File: rtl/arb_prio_slot.sv
module arb_prio_slot #(
  parameter int unsigned PRIO_W    = 3,
  parameter int unsigned INIT_PRIO = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en_i,
  input  logic              won_i,
  input  logic [PRIO_W-1:0] win_prio_i,
  output logic [PRIO_W-1:0] prio_o
);
  logic [PRIO_W-1:0] prio_q, prio_d;

  always_comb begin
    prio_d = prio_q;
    if (won_i)                    prio_d = '0;
    else if (prio_q < win_prio_i) prio_d = prio_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prio_q <= PRIO_W'(INIT_PRIO);
    else if (upd_en_i) prio_q <= prio_d;
  end

  assign prio_o = prio_q;
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int unsigned N_INIT = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [N_INIT-1:0]             req_i,
  input  logic [N_INIT-1:0][PRIO_W-1:0] prio_i,
  output logic [N_INIT-1:0]             grant_o,
  output logic                          any_o,
  output logic [PRIO_W-1:0]             win_prio_o,
  output logic [IDX_W-1:0]              winner_o
);
  localparam int unsigned N_LINES = 2 ** PRIO_W;

  logic [N_LINES-1:0] line;

  always_comb begin
    line = '0;
    for (int i = 0; i < N_INIT; i++)
      if (req_i[i]) line[prio_i[i]] = 1'b1;
  end

  always_comb begin
    win_prio_o = '0;
    for (int p = 0; p < N_LINES; p++)
      if (line[p]) win_prio_o = PRIO_W'(p);
  end

  assign any_o = |line;

  always_comb begin
    winner_o = '0;
    for (int i = 0; i < N_INIT; i++) begin
      grant_o[i] = any_o && req_i[i] && (prio_i[i] == win_prio_o);
      if (grant_o[i]) winner_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/bus_prio_arbiter.sv
module bus_prio_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned N_INIT = ARB_INITS,
  parameter int unsigned SLOT_W = ARB_SLOT_W,
  parameter int unsigned SUB_W  = ARB_SUB_W,
  parameter int unsigned RD_GAP = ARB_RD_GAP,
  parameter int unsigned WR_GAP = ARB_WR_GAP,
  localparam int unsigned PRIO_W = $clog2(N_INIT),
  localparam int unsigned TGT_W  = SLOT_W + SUB_W,
  localparam int unsigned N_TGT  = 2 ** TGT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_INIT-1:0]       req_i,
  input  logic [N_INIT*TGT_W-1:0] tgt_i,
  input  logic                    op_start_i,
  input  logic                    op_write_i,
  input  logic [TGT_W-1:0]        op_tgt_i,
  output logic [N_INIT-1:0]       grant_o,
  output logic                    grant_valid_o,
  output logic [PRIO_W-1:0]       winner_o,
  output logic [N_INIT-1:0]       may_arb_o
);
  logic [N_INIT-1:0][PRIO_W-1:0] prio_q;
  logic [N_TGT-1:0]              tgt_free;
  logic [N_INIT-1:0]             req_eff;
  logic [PRIO_W-1:0]             win_prio;

  arb_target_timer #(
    .N_TGT (N_TGT),
    .TGT_W (TGT_W),
    .RD_GAP(RD_GAP),
    .WR_GAP(WR_GAP)
  ) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(op_start_i),
    .write_i(op_write_i),
    .tgt_i  (op_tgt_i),
    .free_o (tgt_free)
  );

  for (genvar i = 0; i < N_INIT; i++) begin : g_init
    assign may_arb_o[i] = tgt_free[tgt_i[i*TGT_W +: TGT_W]];
    assign req_eff[i]   = req_i[i] & may_arb_o[i];

    arb_prio_slot #(
      .PRIO_W   (PRIO_W),
      .INIT_PRIO(i)
    ) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_en_i  (grant_valid_o),
      .won_i     (grant_o[i]),
      .win_prio_i(win_prio),
      .prio_o    (prio_q[i])
    );
  end

  arb_pick #(
    .N_INIT(N_INIT),
    .PRIO_W(PRIO_W),
    .IDX_W (PRIO_W)
  ) pick_i (
    .req_i     (req_eff),
    .prio_i    (prio_q),
    .grant_o   (grant_o),
    .any_o     (grant_valid_o),
    .win_prio_o(win_prio),
    .winner_o  (winner_o)
  );
endmodule

// File: rtl/bus_prio_arbiter_chk.sv
module bus_prio_arbiter_chk #(
  parameter int unsigned N_INIT = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned TGT_W  = 7,
  parameter int unsigned N_TGT  = 128
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [N_INIT-1:0]             req_i,
  input logic                          op_start_i,
  input logic [TGT_W-1:0]              op_tgt_i,
  input logic [N_INIT-1:0]             grant_o,
  input logic                          grant_valid_o,
  input logic [PRIO_W-1:0]             winner_o,
  input logic [N_INIT-1:0]             may_arb_o,
  input logic [N_INIT-1:0][PRIO_W-1:0] prio_q,
  input logic [N_TGT-1:0]              tgt_free
);
  logic [N_INIT-1:0] seen;

  always_comb begin
    seen = '0;
    for (int i = 0; i < N_INIT; i++) seen[prio_q[i]] = 1'b1;
  end

  // R10
  prio_perm_chk: assert property (@(posedge clk) disable iff (!rst_n) (&seen));

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (grant_valid_o == (grant_o != '0)));

  // R9
  grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~(req_i & may_arb_o)) == '0);

  // R3
  winner_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |=> (prio_q[$past(winner_o)] == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid_o |=> $stable(prio_q));

  // R7
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_start_i |=> !tgt_free[$past(op_tgt_i)]);
endmodule

bind bus_prio_arbiter bus_prio_arbiter_chk #(
  .N_INIT(N_INIT),
  .PRIO_W(PRIO_W),
  .TGT_W (TGT_W),
  .N_TGT (N_TGT)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_i        (req_i),
  .op_start_i   (op_start_i),
  .op_tgt_i     (op_tgt_i),
  .grant_o      (grant_o),
  .grant_valid_o(grant_valid_o),
  .winner_o     (winner_o),
  .may_arb_o    (may_arb_o),
  .prio_q       (prio_q),
  .tgt_free     (tgt_free)
);

// File: tb/bus_prio_arbiter_tb.sv
module bus_prio_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  req;
  logic [55:0] tgt;
  logic        op_start, op_write;
  logic [6:0]  op_tgt;
  logic [7:0]  grant;
  logic        gvalid;
  logic [2:0]  winner;
  logic [7:0]  may_arb;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bus_prio_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .tgt_i(tgt),
    .op_start_i(op_start), .op_write_i(op_write), .op_tgt_i(op_tgt),
    .grant_o(grant), .grant_valid_o(gvalid), .winner_o(winner),
    .may_arb_o(may_arb)
  );

  // {request vector, expected valid, expected winner}, chained from reset
  localparam logic [11:0] VEC [0:8] = '{
    {8'hFF, 1'b1, 3'd7},
    {8'h01, 1'b1, 3'd0},
    {8'h00, 1'b0, 3'd0},
    {8'h81, 1'b1, 3'd7},
    {8'h41, 1'b1, 3'd6},
    {8'h48, 1'b1, 3'd3},
    {8'h30, 1'b1, 3'd5},
    {8'hFF, 1'b1, 3'd4},
    {8'h0E, 1'b1, 3'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] r, input logic st, input logic wr, input logic [6:0] tg);
    @(negedge clk);
    req = r; op_start = st; op_write = wr; op_tgt = tg;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; op_start = 1'b0; op_write = 1'b0; op_tgt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tgt = '0;
    do_reset();
    #1;
    chk("R1 may_arb after reset", 32'(may_arb), 32'hFF);
    chk("R5 no grant after reset", 32'(grant), 32'h0);

    // R2 R3 R4 R5 chained vector walk
    for (int k = 0; k < 9; k++) begin
      drive(VEC[k][11:4], 1'b0, 1'b0, 7'd0);
      chk($sformatf("R2 valid vec %0d", k), 32'(gvalid), 32'(VEC[k][3]));
      if (VEC[k][3]) begin
        chk($sformatf("R2 winner vec %0d", k), 32'(winner), 32'(VEC[k][2:0]));
        chk($sformatf("R4 grant vec %0d", k), 32'(grant), 32'(8'h01 << VEC[k][2:0]));
      end else begin
        chk($sformatf("R5 grant vec %0d", k), 32'(grant), 32'h0);
      end
    end

    // R6 round robin under full load from reset
    do_reset();
    for (int k = 0; k < 16; k++) begin
      drive(8'hFF, 1'b0, 1'b0, 7'd0);
      chk($sformatf("R6 winner step %0d", k), 32'(winner), 32'(7 - (k % 8)));
    end

    // R7 R9 read window on target slot 3 subnode 5 = 29, used by initiator 7
    do_reset();
    tgt = '0;
    tgt[7*7 +: 7] = 7'd29;
    drive(8'h00, 1'b1, 1'b0, 7'd29);
    chk("R7 open in start cycle", 32'(may_arb[7]), 32'h1);
    for (int c = 1; c <= 8; c++) begin
      if (c == 1) begin
        drive(8'h81, 1'b0, 1'b0, 7'd0);
        chk("R9 blocked high requester skipped", 32'(winner), 32'h0);
        chk("R9 other initiator open", 32'(may_arb[0]), 32'h1);
      end else begin
        drive(8'h00, 1'b0, 1'b0, 7'd0);
      end
      chk($sformatf("R7 closed cycle t+%0d", c), 32'(may_arb[7]), 32'h0);
    end
    drive(8'h00, 1'b0, 1'b0, 7'd0);
    chk("R7 reopens at t+9", 32'(may_arb[7]), 32'h1);

    // R8 write window
    drive(8'h00, 1'b1, 1'b1, 7'd29);
    for (int c = 1; c <= 9; c++) begin
      drive(8'h00, 1'b0, 1'b0, 7'd0);
      chk($sformatf("R8 closed cycle t+%0d", c), 32'(may_arb[7]), 32'h0);
    end
    drive(8'h80, 1'b0, 1'b0, 7'd0);
    chk("R8 reopens at t+10", 32'(may_arb[7]), 32'h1);
    chk("R8 granted after reopen", 32'(grant), 32'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule